// File: doc/BRIEF.md
# Remote-Control Interval Timer with Carrier Gating

This block measures out fixed intervals for an infrared remote-control transmitter. A 10-bit start value is written through a load strobe. Any nonzero value starts a down count. A prescaler derives the count rate from the system clock. It divides by a short or a long ratio, and a slow-select control picks between them. Once the counter has run through zero, the timer stops. It then holds a completion flag until the next start. If the processor has halted to wait for this timer, a one-cycle wake pulse releases it.

With output enabled, two pins report the timer's state in opposite senses. The status pin is low while counting and high when stopped. The transmit pin is high while counting and low when stopped. Instead of a steady high, the transmit pin can pass an externally generated carrier through while counting, which produces a modulated burst. With output disabled, the status pin idles high and the transmit pin idles low. Asynchronous reset is released through a two-flop synchronizer, which adds two cycles of reset latency after rst_n rises.

Top module: `rc_interval_timer`

## Requirements
- R1: A load strobe with a nonzero value starts the timer: `done` goes low in the cycle after the load edge.
- R2: A load of zero stops a running timer at once: `done` is high in the cycle after the load edge. A zero load while already stopped changes no output.
- R3: While running, the counter steps down once every DIV_SHORT clocks when `slow_sel` is 0, and once every DIV_LONG clocks when `slow_sel` is 1.
- R4: For a load value V, the timer runs for exactly (V+1)×period clocks and then stops by itself.
- R5: `done` is high exactly when the timer is stopped, and it stays high until the next nonzero load.
- R6: `wake` is a one-cycle pulse in the first stopped cycle. It fires only if `halt_wait` was high at the stopping edge. The stop may come from the count running out or from a zero load.
- R7: With `out_en`=1, `led_o` is 0 while running and 1 while stopped.
- R8: With `out_en`=1, `rem_o` is 0 while stopped. While running, `rem_o` is 1 when `carrier_dis`=1 and follows `carrier_in` when `carrier_dis`=0.
- R9: With `out_en`=0, `led_o` is 1 and `rem_o` is 0 whatever the timer does.
- R10: After reset the timer is stopped: `done`=1, `wake`=0, `led_o`=1, `rem_o`=0.
- R11: A nonzero load while running restarts the count with the new value and clears the prescaler, so the new interval is timed in full from the reload edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_en | input | 1 | Load strobe for the start value |
| load_val | input | CNT_W | Start value |
| slow_sel | input | 1 | 1 selects the long prescale ratio |
| carrier_dis | input | 1 | 1 gives steady high on rem_o while running; 0 gates carrier_in onto it |
| out_en | input | 1 | Enables status on led_o and rem_o |
| carrier_in | input | 1 | Externally generated carrier |
| halt_wait | input | 1 | Core is halted waiting for timer completion |
| done | output | 1 | Completion flag (timer stopped, counter zero) |
| wake | output | 1 | One-cycle halt-release pulse |
| led_o | output | 1 | Status pin, low while running |
| rem_o | output | 1 | Transmit pin, high or carrier while running |

## Verification
The bench builds the timer with CNT_W=10, DIV_SHORT=4 and DIV_LONG=8. These small divide ratios put the full 10-bit load range, including the maximum value 1023 at the long ratio, within a short run. The run lengths can therefore be counted cycle by cycle for both prescale settings. Random load values, control settings and carrier toggling are mixed with directed cases: reload mid-run, a zero load while running and while stopped, output disabled, and wake with and without a halted core.

// File: rtl/rcit_pkg.sv
package rcit_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_e;
endpackage

// File: rtl/rcit_prescaler.sv
module rcit_prescaler #(
  parameter int DIV_SHORT = 64,
  parameter int DIV_LONG  = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  input  logic slow_sel,
  output logic tick
);
  localparam int PW = (DIV_LONG > 2) ? $clog2(DIV_LONG) : 1;
  localparam logic [PW-1:0] LIM_SHORT = PW'(DIV_SHORT - 1);
  localparam logic [PW-1:0] LIM_LONG  = PW'(DIV_LONG - 1);

  logic [PW-1:0] pre_q, pre_d;
  logic [PW-1:0] limit;

  always_comb begin
    limit = slow_sel ? LIM_LONG : LIM_SHORT;
    tick  = run && !clear && (pre_q == limit);
    if (clear || !run || tick) pre_d = '0;
    else                       pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  // R11: a fresh load never ticks in the following cycle
  p_clear_no_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !tick);
endmodule

// File: rtl/rcit_down_counter.sv
module rcit_down_counter
  import rcit_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic             running,
  output logic             cnt_zero,
  output logic             stop_evt
);
  run_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             val_zero;

  always_comb begin
    val_zero = (load_val == '0);
    st_d     = st_q;
    cnt_d    = cnt_q;
    stop_evt = 1'b0;
    if (load_en) begin
      if (val_zero) begin
        st_d     = ST_IDLE;
        cnt_d    = '0;
        stop_evt = (st_q == ST_RUN);
      end else begin
        st_d  = ST_RUN;
        cnt_d = load_val;
      end
    end else if (st_q == ST_RUN && tick) begin
      if (cnt_q == '0) begin
        st_d     = ST_IDLE;
        stop_evt = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign running  = (st_q == ST_RUN);
  assign cnt_zero = (cnt_q == '0);

  p_load_starts_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && load_val != '0) |=> running);
  p_zero_load_stops_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && load_val == '0) |=> !running);
  p_decrement_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (running && tick && !load_en && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load_en) |=> $stable(cnt_q));
  p_idle_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> cnt_zero);
endmodule

// File: rtl/rcit_pin_mux.sv
module rcit_pin_mux (
  input  logic clk,
  input  logic rst_n,
  input  logic running,
  input  logic out_en,
  input  logic carrier_dis,
  input  logic carrier_in,
  output logic led_o,
  output logic rem_o
);
  logic run_level;

  always_comb begin
    run_level = carrier_dis ? 1'b1 : carrier_in;
    led_o     = out_en ? !running : 1'b1;
    rem_o     = out_en && running && run_level;
  end

  p_pins_opposed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rem_o |-> !led_o);
  p_rem_idle_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !rem_o);
  p_disabled_pins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |-> (led_o && !rem_o));
endmodule

// File: rtl/rc_interval_timer.sv
module rc_interval_timer #(
  parameter int CNT_W     = 10,
  parameter int DIV_SHORT = 64,
  parameter int DIV_LONG  = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic             slow_sel,
  input  logic             carrier_dis,
  input  logic             out_en,
  input  logic             carrier_in,
  input  logic             halt_wait,
  output logic             done,
  output logic             wake,
  output logic             led_o,
  output logic             rem_o
);
  logic [1:0] rst_sync_q;
  logic       rst_i_n;
  logic       tick, running, cnt_zero, stop_evt;
  logic       wake_q, wake_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  rcit_prescaler #(.DIV_SHORT(DIV_SHORT), .DIV_LONG(DIV_LONG)) u_pre (
    .clk(clk), .rst_n(rst_i_n), .clear(load_en), .run(running),
    .slow_sel(slow_sel), .tick(tick));

  rcit_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_i_n), .load_en(load_en), .load_val(load_val),
    .tick(tick), .running(running), .cnt_zero(cnt_zero), .stop_evt(stop_evt));

  rcit_pin_mux u_mux (
    .clk(clk), .rst_n(rst_i_n), .running(running), .out_en(out_en),
    .carrier_dis(carrier_dis), .carrier_in(carrier_in),
    .led_o(led_o), .rem_o(rem_o));

  always_comb wake_d = stop_evt && halt_wait;

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) wake_q <= 1'b0;
    else          wake_q <= wake_d;
  end

  assign wake = wake_q;
  assign done = !running && cnt_zero;

  p_wake_cause_r6: assert property (@(posedge clk) disable iff (!rst_i_n)
    wake |-> (done && $past(halt_wait)));
  p_wake_single_r6: assert property (@(posedge clk) disable iff (!rst_i_n)
    wake |=> !wake);
  p_done_until_load_r5: assert property (@(posedge clk) disable iff (!rst_i_n)
    (done && !load_en) |=> done);
endmodule

// File: tb/rc_interval_timer_test.sv
module rc_interval_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 10;
  localparam int DS = 4;
  localparam int DL = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic load_en, slow_sel, carrier_dis, out_en, carrier_in, halt_wait;
  logic [CNT_W-1:0] load_val;
  logic done, wake, led_o, rem_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rc_interval_timer #(.CNT_W(CNT_W), .DIV_SHORT(DS), .DIV_LONG(DL)) uut (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_val(load_val),
    .slow_sel(slow_sel), .carrier_dis(carrier_dis), .out_en(out_en),
    .carrier_in(carrier_in), .halt_wait(halt_wait), .done(done),
    .wake(wake), .led_o(led_o), .rem_o(rem_o));

  function automatic int exp_len(input int v, input logic slow);
    return (v + 1) * (slow ? DL : DS);
  endfunction

  function automatic logic exp_led(input logic oe, input logic run);
    return oe ? !run : 1'b1;
  endfunction

  function automatic logic exp_rem(input logic oe, input logic run,
                                   input logic cdis, input logic car);
    return oe && run && (cdis ? 1'b1 : car);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_load(input int v);
    @(negedge clk);
    load_en = 1'b1;
    load_val = CNT_W'(v);
    @(negedge clk);
    load_en = 1'b0;
  endtask

  // Runs from the negedge after a load until the timer stops; returns run length
  task automatic measure(output int len);
    len = 0;
    while (!done && len < 20000) begin
      carrier_in = 1'($urandom);
      #1;
      chk("R7 led while running", led_o, exp_led(out_en, 1'b1));
      chk("R8/R9 rem while running", rem_o, exp_rem(out_en, 1'b1, carrier_dis, carrier_in));
      len++;
      @(negedge clk);
    end
  endtask

  task automatic full_run(input int v, input logic slow, input logic cdis,
                          input logic oe, input logic hw);
    int len;
    slow_sel = slow; carrier_dis = cdis; out_en = oe; halt_wait = hw;
    do_load(v);
    chk("R1 started", done, 0);
    measure(len);
    chk("R3/R4 run length", len, exp_len(v, slow));
    chk("R5 done after run", done, 1);
    chk("R6 wake pulse", wake, hw);
    chk("R7 led stopped", led_o, 1);
    chk("R8 rem stopped", rem_o, 0);
    @(negedge clk);
    chk("R6 wake single", wake, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int len;
    void'($urandom(32'd7341));
    rst_n = 1'b0; load_en = 1'b0; load_val = '0; slow_sel = 1'b0;
    carrier_dis = 1'b1; out_en = 1'b1; carrier_in = 1'b0; halt_wait = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10 reset state
    chk("R10 done", done, 1);
    chk("R10 wake", wake, 0);
    chk("R10 led", led_o, 1);
    chk("R10 rem", rem_o, 0);

    // Directed: smallest, both ratios, max value
    full_run(1, 1'b0, 1'b1, 1'b1, 1'b1);
    full_run(1, 1'b1, 1'b0, 1'b1, 1'b0);
    full_run(1023, 1'b1, 1'b1, 1'b1, 1'b1);

    // R9 output disabled
    full_run(5, 1'b0, 1'b0, 1'b0, 1'b0);

    // R11 reload while running
    slow_sel = 1'b0; out_en = 1'b1; halt_wait = 1'b0;
    do_load(20);
    repeat (13) @(negedge clk);
    do_load(5);
    measure(len);
    chk("R11 reload length", len, exp_len(5, 1'b0));

    // R2 zero load while running, with halted core
    halt_wait = 1'b1;
    do_load(30);
    repeat (7) @(negedge clk);
    chk("R2 running before zero load", done, 0);
    do_load(0);
    #1;
    chk("R2 done after zero load", done, 1);
    chk("R6 wake on zero load", wake, 1);
    chk("R7 led after zero load", led_o, 1);
    @(negedge clk);
    chk("R6 wake single", wake, 0);

    // R2 zero load while stopped: nothing changes
    do_load(0);
    #1;
    chk("R2 idle zero load done", done, 1);
    chk("R2 idle zero load wake", wake, 0);
    chk("R2 idle zero load led", led_o, 1);
    chk("R2 idle zero load rem", rem_o, 0);

    // Random runs
    for (int i = 0; i < 12; i++) begin
      int v;
      v = ($urandom % 4 == 0) ? int'($urandom % 1024) : int'($urandom % 40);
      if (v == 0) v = 1;
      full_run(v, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule